// File: doc/BRIEF.md
# Rotating-Store Three-Address Instruction Sequencer

This block is the control unit of a serial machine whose main store is a rotating drum of 512 thirty-bit words, organised as 8 channels of 64 word positions. A free-running position counter stands in for the drum's rotation: each clock is one word time, and only the word currently passing under the heads can be read or written. The sequencer drives the channel select, and it moves data only when the rotating position matches the word field of the address it is waiting for.

Each instruction runs in four major phases. K0 fetches the instruction at the program counter. K1 fetches the first operand. K2 fetches the second operand and forms the result. K3 writes the result back. Add, subtract and bitwise AND are done inside the block. The three multiply codes are handed to a neighbouring multiplier over a request/done handshake. Code 7 is a three-way branch on the sign of the first operand. An all-zero word stops the machine. An arithmetic overflow stops it with a separate indicator.

An instruction word is laid out as follows. Bits 29:27 hold the operation code. Bits 26:18 hold address A1, bits 17:9 hold A2, and bits 8:0 hold A3. Within an address, bits 8:6 are the channel and bits 5:0 are the word position. Numbers are 30-bit two's complement.

Top module: `drum_seq`

## Requirements
- R1: While reset is held, and on the first clock after it, the outputs show phase K0 (code 0), `pc` = 0, `mem_pos` = 0, `mem_we` = 0, `mul_req` = 0, and both halt indicators low.
- R2: `mem_pos` advances by one every clock and wraps from 63 to 0, whether or not the machine is halted.
- R3: Each time a phase is entered, no transfer happens in it until at least SETTLE enabled word times (default 2) have passed. After that, the transfer happens in the first clock where `mem_pos` equals the word field (bits 5:0) of the target address. `mem_chan` always shows the channel field (bits 8:6) of the target.
- R4: The targets are `pc` in K0, A1 in K1, A2 in K2 and A3 in K3, and the phases run in that order. A non-zero fetch loads the instruction and increments `pc` by one. The K3 transfer asserts `mem_we` with the result for one clock, and then phase returns to K0.
- R5: Code 4 stores (A1)+(A2) into A3. Code 5 stores (A2)−(A1) into A3. Code 6 stores (A1) AND (A2) into A3.
- R6: If an add or subtract result does not fit in 30-bit two's complement, the machine raises `halt_ovf`. Nothing is written, and all state then freezes.
- R7: Codes 1 to 3 hold `mul_req` high in K3, with `mul_op`, `mul_a` = (A1) and `mul_b` = (A2) stable, until `mul_done` is seen. No write happens before that. The result then comes from `mul_result` and is written to A3, unless `mul_ovf` is high, in which case the machine halts as in R6.
- R8: Code 7 reads (A1) and then returns from K2 straight to K0 with no write. The next fetch address depends on (A1): if bit 29 is set (negative), it is the incremented `pc`; if (A1) is zero, it is A2; otherwise (positive) it is A3.
- R9: A fetched word of all zeros raises `halt_stop`, leaves `pc` at that word's address, and freezes all state. `halt_stop` and `halt_ovf` are never high together.
- R10: Code 0 with any non-zero address bits does nothing: `pc` increments, no operand is read, nothing is written, and the next fetch follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one word time per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_chan | output | 3 | Channel select for the target address |
| mem_pos | output | 6 | Current rotating word position |
| mem_rdata | input | 30 | Word at (mem_chan, mem_pos), combinational |
| mem_wdata | output | 30 | Result being written |
| mem_we | output | 1 | Write the result at (mem_chan, mem_pos) this clock |
| mul_req | output | 1 | Multiplier request, held until done |
| mul_op | output | 3 | Multiply operation code (1 to 3) |
| mul_a | output | 30 | First multiplier operand (A1) |
| mul_b | output | 30 | Second multiplier operand (A2) |
| mul_done | input | 1 | Multiplier result valid |
| mul_result | input | 30 | Multiplier result word |
| mul_ovf | input | 1 | Multiplier result out of range |
| phase | output | 2 | Current major phase, K0 to K3 as 0 to 3 |
| pc | output | 9 | Instruction address register |
| halt_stop | output | 1 | Stopped on an all-zero instruction |
| halt_ovf | output | 1 | Stopped on overflow |

## Verification
A corrupted settle count or coincidence compare moves the write into the wrong drum cell, or too early in K3. The bench sees that in the memory model as soon as the program halts, and its monitor sees a short K3-to-write gap in the cycle of the write. A wrong phase or program-counter update shows up at the next transition as an illegal `phase` step, or at the halt as a `pc` that differs from the expected halt address. Wrong branch or arithmetic decisions show up at the end of each table row, either in the stored result or in which halt indicator is raised.

// File: rtl/drum_seq_pkg.sv
// Shared types and operation codes for the rotating-store sequencer.
// Assumes a 3-bit operation code in the top bits of the instruction word.
package drum_seq_pkg;

    typedef enum logic [1:0] {
        PH_K0 = 2'd0,
        PH_K1 = 2'd1,
        PH_K2 = 2'd2,
        PH_K3 = 2'd3
    } phase_e;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_NOP  = 3'd0;
    localparam logic [OP_W-1:0] OP_MUL1 = 3'd1;
    localparam logic [OP_W-1:0] OP_MUL2 = 3'd2;
    localparam logic [OP_W-1:0] OP_MUL3 = 3'd3;
    localparam logic [OP_W-1:0] OP_ADD  = 3'd4;
    localparam logic [OP_W-1:0] OP_SUB  = 3'd5;
    localparam logic [OP_W-1:0] OP_AND  = 3'd6;
    localparam logic [OP_W-1:0] OP_BR   = 3'd7;

    // True for the codes served by the external multiplier.
    function automatic logic op_is_mul(input logic [OP_W-1:0] op);
        return (op == OP_MUL1) || (op == OP_MUL2) || (op == OP_MUL3);
    endfunction

endpackage

// File: rtl/drum_rotation.sv
// Rotation model and angular-coincidence detector.
// A position counter advances once per word time. After each arm pulse
// (phase entry) a settle counter must count SETTLE enabled word times
// before the coincidence compare may fire.
// Assumes arm is pulsed in the cycle a phase is left, so the next phase
// starts with a full settle window.
module drum_rotation #(
    parameter int POS_W  = 6,
    parameter int SETTLE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             enable,
    input  logic [POS_W-1:0] target_word,
    output logic [POS_W-1:0] pos,
    output logic             hit
);
    localparam int CNT_W = $clog2(SETTLE + 2);
    localparam logic [CNT_W-1:0] SETTLE_L = CNT_W'(SETTLE);

    logic [POS_W-1:0] pos_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] since_q;

    // Rotation: one word position per clock, wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_q + 1'b1;
    end

    // Channel-select settle window, reloaded on every phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= SETTLE_L;
        else if (arm)                   cnt_q <= SETTLE_L;
        else if (enable && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Coincidence: settled and the rotating position is the target word.
    always_comb begin
        hit = enable && (cnt_q == '0) && (pos_q == target_word);
    end

    assign pos = pos_q;

    // Checker state: word times since the last phase entry, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || arm)          since_q <= '0;
        else if (since_q < SETTLE_L) since_q <= since_q + 1'b1;
    end

    // R2: rotation advances by exactly one per clock.
    p_pos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pos_q == POS_W'($past(pos_q) + 1'b1)));

    // R3: no coincidence before the settle window has elapsed.
    p_settle_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (since_q == SETTLE_L));

endmodule

// File: rtl/drum_alu.sv
// Internal arithmetic for add, reverse subtract and AND, with
// two's-complement overflow detection on the WORD_W-bit result.
// Assumes a is (A1) and b is (A2); subtract forms b - a.
module drum_alu
    import drum_seq_pkg::*;
#(
    parameter int WORD_W = 30
) (
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] y,
    output logic              ovf
);
    logic [WORD_W:0] sum_x;
    logic [WORD_W:0] dif_x;

    // Sign-extended sum and difference; overflow when the top two bits differ.
    always_comb begin
        sum_x = {a[WORD_W-1], a} + {b[WORD_W-1], b};
        dif_x = {b[WORD_W-1], b} - {a[WORD_W-1], a};
        y     = '0;
        ovf   = 1'b0;
        case (op)
            OP_ADD: begin
                y   = sum_x[WORD_W-1:0];
                ovf = sum_x[WORD_W] ^ sum_x[WORD_W-1];
            end
            OP_SUB: begin
                y   = dif_x[WORD_W-1:0];
                ovf = dif_x[WORD_W] ^ dif_x[WORD_W-1];
            end
            OP_AND: y = a & b;
            default: ;
        endcase
    end
endmodule

// File: rtl/drum_branch_sel.sv
// Three-way next-address choice for the sign branch.
// Assumes seq_pc is already the incremented program counter.
module drum_branch_sel #(
    parameter int WORD_W = 30,
    parameter int ADDR_W = 9
) (
    input  logic [WORD_W-1:0] val,
    input  logic [ADDR_W-1:0] seq_pc,
    input  logic [ADDR_W-1:0] on_zero,
    input  logic [ADDR_W-1:0] on_pos,
    output logic [ADDR_W-1:0] next_pc
);
    // Negative continues in sequence, zero takes A2, positive takes A3.
    always_comb begin
        if (val[WORD_W-1])   next_pc = seq_pc;
        else if (val == '0)  next_pc = on_zero;
        else                 next_pc = on_pos;
    end
endmodule

// File: rtl/drum_seq.sv
// Three-address instruction sequencer for a rotating word store.
// Runs phases K0..K3 (fetch, operand 1, operand 2, write-back). Every
// transfer waits for the drum to bring the target word round after a
// channel settle window. Multiply codes use an external multiplier.
// Assumes a combinational read of the word at (mem_chan, mem_pos), and
// WORD_W == OP_W + 3 * (CHAN_W + POS_W).
module drum_seq
    import drum_seq_pkg::*;
#(
    parameter int WORD_W = 30,
    parameter int CHAN_W = 3,
    parameter int POS_W  = 6,
    parameter int SETTLE = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [CHAN_W-1:0]          mem_chan,
    output logic [POS_W-1:0]           mem_pos,
    input  logic [WORD_W-1:0]          mem_rdata,
    output logic [WORD_W-1:0]          mem_wdata,
    output logic                       mem_we,
    output logic                       mul_req,
    output logic [2:0]                 mul_op,
    output logic [WORD_W-1:0]          mul_a,
    output logic [WORD_W-1:0]          mul_b,
    input  logic                       mul_done,
    input  logic [WORD_W-1:0]          mul_result,
    input  logic                       mul_ovf,
    output logic [1:0]                 phase,
    output logic [CHAN_W+POS_W-1:0]    pc,
    output logic                       halt_stop,
    output logic                       halt_ovf
);
    localparam int ADDR_W = CHAN_W + POS_W;
    localparam int A3_LO  = 0;
    localparam int A2_LO  = ADDR_W;
    localparam int A1_LO  = 2 * ADDR_W;
    localparam int OP_LO  = WORD_W - OP_W;

    phase_e              phase_q;
    logic [ADDR_W-1:0]   pc_q;
    logic [WORD_W-1:0]   ir_q;
    logic [WORD_W-1:0]   opa_q;
    logic [WORD_W-1:0]   opb_q;
    logic [WORD_W-1:0]   res_q;
    logic                res_ok_q;
    logic                stop_q;
    logic                ovf_q;

    logic [OP_W-1:0]     ir_op;
    logic [OP_W-1:0]     rd_op;
    logic [ADDR_W-1:0]   a1, a2, a3;
    logic [ADDR_W-1:0]   target;
    logic [ADDR_W-1:0]   br_next;
    logic [WORD_W-1:0]   alu_y;
    logic                alu_ovf;
    logic                running;
    logic                is_branch;
    logic                is_mul;
    logic                waiting_mul;
    logic                rot_enable;
    logic                rot_arm;
    logic                hit;

    // Instruction field decode from the held instruction and the read bus.
    always_comb begin
        ir_op     = ir_q[WORD_W-1:OP_LO];
        rd_op     = mem_rdata[WORD_W-1:OP_LO];
        a1        = ir_q[A1_LO +: ADDR_W];
        a2        = ir_q[A2_LO +: ADDR_W];
        a3        = ir_q[A3_LO +: ADDR_W];
        running   = !stop_q && !ovf_q;
        is_branch = (ir_op == OP_BR);
        is_mul    = op_is_mul(ir_op);
        waiting_mul = (phase_q == PH_K3) && !res_ok_q;
    end

    // Target address of the current phase.
    always_comb begin
        unique case (phase_q)
            PH_K0: target = pc_q;
            PH_K1: target = a1;
            PH_K2: target = a2;
            PH_K3: target = a3;
        endcase
    end

    // Rotation and settle control: paused while halted, while the branch
    // resolves in K2, and while the multiplier is busy.
    always_comb begin
        rot_enable = running && !((phase_q == PH_K2) && is_branch) && !waiting_mul;
        rot_arm    = running && (hit || ((phase_q == PH_K2) && is_branch));
    end

    drum_rotation #(
        .POS_W  (POS_W),
        .SETTLE (SETTLE)
    ) u_rot (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (rot_arm),
        .enable      (rot_enable),
        .target_word (target[POS_W-1:0]),
        .pos         (mem_pos),
        .hit         (hit)
    );

    drum_alu #(
        .WORD_W (WORD_W)
    ) u_alu (
        .op  (ir_op),
        .a   (opa_q),
        .b   (mem_rdata),
        .y   (alu_y),
        .ovf (alu_ovf)
    );

    drum_branch_sel #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_br (
        .val     (opa_q),
        .seq_pc  (pc_q),
        .on_zero (a2),
        .on_pos  (a3),
        .next_pc (br_next)
    );

    // Phase sequencing, operand capture, result and halt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_K0;
            pc_q     <= '0;
            ir_q     <= '0;
            opa_q    <= '0;
            opb_q    <= '0;
            res_q    <= '0;
            res_ok_q <= 1'b0;
            stop_q   <= 1'b0;
            ovf_q    <= 1'b0;
        end else if (running) begin
            unique case (phase_q)
                PH_K0: if (hit) begin
                    if (mem_rdata == '0) begin
                        stop_q <= 1'b1;
                    end else begin
                        ir_q <= mem_rdata;
                        pc_q <= pc_q + 1'b1;
                        if (rd_op != OP_NOP) phase_q <= PH_K1;
                    end
                end
                PH_K1: if (hit) begin
                    opa_q   <= mem_rdata;
                    phase_q <= PH_K2;
                end
                PH_K2: begin
                    if (is_branch) begin
                        pc_q    <= br_next;
                        phase_q <= PH_K0;
                    end else if (hit) begin
                        opb_q <= mem_rdata;
                        if (is_mul) begin
                            res_ok_q <= 1'b0;
                            phase_q  <= PH_K3;
                        end else if (alu_ovf) begin
                            ovf_q <= 1'b1;
                        end else begin
                            res_q    <= alu_y;
                            res_ok_q <= 1'b1;
                            phase_q  <= PH_K3;
                        end
                    end
                end
                PH_K3: begin
                    if (!res_ok_q) begin
                        if (mul_done) begin
                            if (mul_ovf) begin
                                ovf_q <= 1'b1;
                            end else begin
                                res_q    <= mul_result;
                                res_ok_q <= 1'b1;
                            end
                        end
                    end else if (hit) begin
                        res_ok_q <= 1'b0;
                        phase_q  <= PH_K0;
                    end
                end
            endcase
        end
    end

    // Port drive: memory write at coincidence in K3, multiplier request.
    always_comb begin
        mem_chan  = target[ADDR_W-1:POS_W];
        mem_we    = running && (phase_q == PH_K3) && res_ok_q && hit;
        mem_wdata = res_q;
        mul_req   = running && waiting_mul;
        mul_op    = ir_op;
        mul_a     = opa_q;
        mul_b     = opb_q;
        phase     = phase_q;
        pc        = pc_q;
        halt_stop = stop_q;
        halt_ovf  = ovf_q;
    end

    // R4: a non-zero fetch advances the program counter by one.
    p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && phase_q == PH_K0 && hit && mem_rdata != '0)
            |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

    // R4: the write-back closes the instruction and returns to K0.
    p_write_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (phase_q == PH_K0));

    // R6: an overflow halt freezes state and never writes.
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> (ovf_q && !mem_we && $stable(pc_q) && $stable(phase_q)));

    // R7: the multiplier request and operands hold until done.
    p_mul_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_req && !mul_done) |=> (mul_req && $stable(mul_a) && $stable(mul_b)));

    // R8: the branch resolves in one K2 cycle and returns to K0.
    p_branch_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && phase_q == PH_K2 && is_branch) |=> (phase_q == PH_K0));

    // R9: a stop halt holds the program counter.
    p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |=> (stop_q && $stable(pc_q)));

    // R9: the two halt indications are exclusive.
    p_halt_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_q && ovf_q));

endmodule

// File: tb/drum_seq_test.sv
`timescale 1ns/1ps
module drum_seq_test;
    localparam int SETTLE = 2;
    localparam logic [29:0] SENT = 30'h00ABCDE;
    localparam logic [8:0]  AD1  = 9'o100;
    localparam logic [8:0]  AD2  = 9'o205;
    localparam logic [8:0]  AD3  = 9'o312;
    localparam logic [8:0]  BZ   = 9'o020;
    localparam logic [8:0]  BP   = 9'o030;

    // Row: op, (A1), (A2), kind, expected. kind 0 = result in A3,
    // 1 = stop halt at expected pc, 2 = overflow halt.
    localparam int NV = 17;
    localparam logic [94:0] VEC [NV] = '{
        {3'd4, 30'd5,          30'd7,          2'd0, 30'd12},
        {3'd4, 30'h3FFFFFFD,   30'd10,         2'd0, 30'd7},
        {3'd4, 30'h1FFFFFFF,   30'd1,          2'd2, 30'd0},
        {3'd4, 30'h20000000,   30'h3FFFFFFF,   2'd2, 30'd0},
        {3'd5, 30'd5,          30'd20,         2'd0, 30'd15},
        {3'd5, 30'd20,         30'd5,          2'd0, 30'h3FFFFFF1},
        {3'd5, 30'd1,          30'h20000000,   2'd2, 30'd0},
        {3'd5, 30'h3FFFFFFF,   30'h1FFFFFFF,   2'd2, 30'd0},
        {3'd6, 30'h0000F0F,    30'h00000FF,    2'd0, 30'h000000F},
        {3'd6, 30'h3FFFFFFF,   30'h15555555,   2'd0, 30'h15555555},
        {3'd1, 30'd6,          30'd7,          2'd0, 30'd42},
        {3'd2, 30'h0010000,    30'h0010000,    2'd2, 30'd0},
        {3'd7, 30'h3FFFFFFF,   30'd0,          2'd1, 30'd1},
        {3'd7, 30'd0,          30'd0,          2'd1, 30'd16},
        {3'd7, 30'd9,          30'd0,          2'd1, 30'd24},
        {3'd0, 30'd3,          30'd4,          2'd1, 30'd1},
        {3'd7, 30'h20000000,   30'd0,          2'd1, 30'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mem_chan;
    logic [5:0]  mem_pos;
    logic [29:0] mem_rdata;
    logic [29:0] mem_wdata;
    logic        mem_we;
    logic        mul_req;
    logic [2:0]  mul_op;
    logic [29:0] mul_a, mul_b;
    logic        mul_done = 1'b0;
    logic [29:0] mul_result = '0;
    logic        mul_ovf = 1'b0;
    logic [1:0]  phase;
    logic [8:0]  pc;
    logic        halt_stop, halt_ovf;

    logic [29:0] mem [0:511];
    int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
    int mul_lat = 4, mul_cnt = 0, cyc = 0, k3_at = 0;
    logic [1:0] prev_phase = 2'd0;

    always #2.5 clk = ~clk;

    drum_seq uut (
        .clk(clk), .rst_n(rst_n), .mem_chan(mem_chan), .mem_pos(mem_pos),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mul_req(mul_req), .mul_op(mul_op), .mul_a(mul_a), .mul_b(mul_b),
        .mul_done(mul_done), .mul_result(mul_result), .mul_ovf(mul_ovf),
        .phase(phase), .pc(pc), .halt_stop(halt_stop), .halt_ovf(halt_ovf)
    );

    // Drum model: combinational read, write on the clock edge.
    assign mem_rdata = mem[{mem_chan, mem_pos}];
    always @(posedge clk) if (mem_we) mem[{mem_chan, mem_pos}] <= mem_wdata;

    // Multiplier model: unsigned product, out of range above 29 bits.
    always @(negedge clk) begin
        logic [59:0] prod;
        prod = {30'd0, mul_a} * {30'd0, mul_b};
        if (mul_req && !mul_done) begin
            mul_cnt = mul_cnt + 1;
            if (mul_cnt >= mul_lat) begin
                mul_result = prod[29:0];
                mul_ovf    = |prod[59:29];
                mul_done   = 1'b1;
            end
        end else begin
            mul_done = 1'b0;
            mul_cnt  = 0;
        end
    end

    // Monitor: legal phase steps, settle gap before writes, no writes halted.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (phase != prev_phase) begin
                mon_checks++;
                if (!((prev_phase == 2'd0 && phase == 2'd1) || (prev_phase == 2'd1 && phase == 2'd2) ||
                      (prev_phase == 2'd2 && phase == 2'd3) || (prev_phase == 2'd2 && phase == 2'd0) ||
                      (prev_phase == 2'd3 && phase == 2'd0))) begin
                    mon_fails++;
                    $display("FAIL R4 phase step act=%0d expected successor of %0d", phase, prev_phase);
                end
                if (phase == 2'd3) k3_at = cyc;
            end
            if (mem_we) begin
                mon_checks++;
                if ((cyc - k3_at) < SETTLE || mul_req || halt_stop || halt_ovf) begin
                    mon_fails++;
                    $display("FAIL R3 write gap act=%0d expected>=%0d (req=%0b)", cyc - k3_at, SETTLE, mul_req);
                end
            end
        end
        prev_phase = phase;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 512; i++) mem[i] = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_to_halt();
        for (int i = 0; i < 4000; i++) begin
            if (halt_stop || halt_ovf) break;
            @(negedge clk);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op, input logic [1:0] kind);
        if (kind == 2'd2)              return "R6";
        if (op == 3'd0)                return "R10";
        if (op == 3'd7)                return "R8";
        if (op >= 3'd1 && op <= 3'd3)  return "R7";
        return "R5";
    endfunction

    initial begin
        // R1: reset state, checked while reset is held.
        clear_mem();
        repeat (3) @(negedge clk);
        check(phase == 2'd0 && pc == 9'd0 && mem_pos == 6'd0, "R1 reset phase/pc/pos",
              {21'd0, phase, pc}, 32'd0);
        check(!mem_we && !mul_req && !halt_stop && !halt_ovf, "R1 reset controls",
              {28'd0, mem_we, mul_req, halt_stop, halt_ovf}, 32'd0);

        // R2: rotation steps by one and wraps.
        begin
            logic [5:0] last;
            bit ok;
            ok = 1'b1;
            rst_n = 1'b1;
            @(negedge clk);
            check(mem_pos == 6'd1, "R2 first step", {26'd0, mem_pos}, 32'd1);
            last = mem_pos;
            for (int i = 0; i < 70; i++) begin
                @(negedge clk);
                if (mem_pos != 6'(last + 1'b1)) ok = 1'b0;
                last = mem_pos;
            end
            check(ok, "R2 wrap", {26'd0, mem_pos}, {26'd0, last});
        end

        // Table walk: one instruction, then a halt word at address 1.
        for (int v = 0; v < NV; v++) begin
            logic [2:0]  op;
            logic [29:0] av, bv, ex;
            logic [1:0]  kind;
            string       tg;
            op = VEC[v][94:92]; av = VEC[v][91:62]; bv = VEC[v][61:32];
            kind = VEC[v][31:30]; ex = VEC[v][29:0];
            tg = tag_of(op, kind);
            clear_mem();
            if (op == 3'd7) mem[0] = {op, AD1, BZ, BP};
            else            mem[0] = {op, AD1, AD2, AD3};
            mem[AD1] = av;
            if (op != 3'd7) begin
                mem[AD2] = bv;
                mem[AD3] = SENT;
            end
            do_reset();
            run_to_halt();
            case (kind)
                2'd0: begin
                    check(halt_stop && !halt_ovf, {tg, " stop after write"}, {30'd0, halt_stop, halt_ovf}, 32'd2);
                    check(pc == 9'd1, "R4 next fetch", {23'd0, pc}, 32'd1);
                    check(mem[AD3] == ex, {tg, " result"}, {2'd0, mem[AD3]}, {2'd0, ex});
                end
                2'd1: begin
                    check(halt_stop && !halt_ovf, {tg, " stop flag"}, {30'd0, halt_stop, halt_ovf}, 32'd2);
                    check(pc == ex[8:0], {tg, " halt address"}, {23'd0, pc}, {2'd0, ex});
                    if (op != 3'd7)
                        check(mem[AD3] == SENT, {tg, " no write"}, {2'd0, mem[AD3]}, {2'd0, SENT});
                end
                default: begin
                    check(halt_ovf && !halt_stop, "R6 overflow flag", {30'd0, halt_stop, halt_ovf}, 32'd1);
                    check(mem[AD3] == SENT, "R6 no write", {2'd0, mem[AD3]}, {2'd0, SENT});
                    check(pc == 9'd1, "R6 pc held", {23'd0, pc}, 32'd1);
                end
            endcase
        end

        // R4/R3: chained program, second instruction uses the first result.
        clear_mem();
        mem[0] = {3'd4, AD1, AD2, AD3};
        mem[1] = {3'd5, AD3, AD1, 9'o313};
        mem[AD1] = 30'd100;
        mem[AD2] = 30'd25;
        do_reset();
        for (int i = 0; i < 500 && phase != 2'd1; i++) @(negedge clk);
        check(phase == 2'd1 && mem_chan == 3'd1, "R3 channel select of A1", {29'd0, mem_chan}, 32'd1);
        run_to_halt();
        check(mem[AD3] == 30'd125, "R4 first result", {2'd0, mem[AD3]}, 32'd125);
        check(mem[9'o313] == 30'h3FFFFFE7, "R4 chained result", {2'd0, mem[9'o313]}, 32'h3FFFFFE7);
        check(pc == 9'd2 && halt_stop, "R9 halt address", {23'd0, pc}, 32'd2);

        // R9: state frozen after a stop halt.
        begin
            logic [8:0] pc0;
            pc0 = pc;
            repeat (100) @(negedge clk);
            check(pc == pc0 && halt_stop && !halt_ovf && phase == 2'd0, "R9 frozen",
                  {23'd0, pc}, {23'd0, pc0});
        end

        // R7: slow multiplier, no write before done.
        mul_lat = 80;
        clear_mem();
        mem[0] = {3'd3, AD1, AD2, AD3};
        mem[AD1] = 30'd3;
        mem[AD2] = 30'd4;
        mem[AD3] = SENT;
        do_reset();
        for (int i = 0; i < 500 && !mul_req; i++) @(negedge clk);
        check(mul_req && mul_op == 3'd3 && mul_a == 30'd3 && mul_b == 30'd4, "R7 request operands",
              {2'd0, mul_a}, 32'd3);
        repeat (40) @(negedge clk);
        check(mul_req && mem[AD3] == SENT && phase == 2'd3, "R7 held in K3", {2'd0, mem[AD3]}, {2'd0, SENT});
        run_to_halt();
        check(mem[AD3] == 30'd12, "R7 slow result", {2'd0, mem[AD3]}, 32'd12);
        mul_lat = 4;

        // R1: reset in mid-run returns to the reset state.
        clear_mem();
        mem[0] = {3'd4, AD1, AD2, AD3};
        do_reset();
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(phase == 2'd0 && pc == 9'd0 && !mem_we && !halt_stop && !halt_ovf, "R1 mid-run reset",
              {21'd0, phase, pc}, 32'd0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", (checks + mon_checks) - (fails + mon_fails), checks + mon_checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog act=timeout expected=completion");
        $display("%0d/%0d checks passed", (checks + mon_checks) - (fails + mon_fails), checks + mon_checks);
        $finish;
    end
endmodule